// File: doc/BRIEF.md
# Autonomous Periodic Interrupt Timer

This block raises a periodic event that does not depend on the system clock running. It counts ticks from one of two sources, chosen by a source-select bit. The first source is an always-on autonomous tick, which arrives as a tick-enable input. The second is the bus clock, which arrives as a "bus clock running" qualifier. When the count reaches the programmed period, a sticky elapsed flag is set and counting starts over at once. If the interrupt enable is set, the flag drives an interrupt request.

Software programs the timer through a small write port with three addresses:

| Address | Contents |
|---|---|
| 0 (control) | bit 0 run, bit 1 source select, bit 2 interrupt enable |
| 1 (period) | period value, bits 15:0 |
| 2 (status) | bit 0: write 1 to clear the elapsed flag |

While the timer runs, the period and the source select are locked, so the configuration cannot change in the middle of a period. Writes to them at that time are dropped. To reprogram, stop the timer, write the new values, then start it again.

Top module: `periodic_tick_timer`

## Requirements
- R1: After reset the timer is stopped, the autonomous source is selected, the interrupt enable is clear, the period is 0, and both the elapsed flag and irq_o are low.
- R2: Once the run bit is set by a write to address 0 bit 0, the elapsed flag rises after the edge that carries the (period+1)-th qualifying tick. Ticks are counted only from the cycle after that write.
- R3: After an expiry the count restarts by itself, so the next expiry comes after another period+1 qualifying ticks.
- R4: With source select = 0 only auto_tick_i counts; with source select = 1 only bus_clk_on_i counts. The unselected input has no effect.
- R5: With the bus source selected, cycles where bus_clk_on_i is low hold the count frozen. Counting resumes where it stopped.
- R6: A write to the period register (address 1) while the timer runs is ignored.
- R7: A write to the source-select bit (address 0 bit 1) while the timer runs is ignored. The run bit and the interrupt enable are still updated by that write.
- R8: irq_o is high exactly when the elapsed flag is high and the interrupt enable (address 0 bit 2) is set.
- R9: Writing 1 to address 2 bit 0 clears the elapsed flag. If an expiry happens in the same cycle, the flag stays set.
- R10: Clearing the run bit returns the count to 0, so the next start always counts a full period.
- R11: A period value of 0 sets the flag on every qualifying tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| auto_tick_i | input | 1 | One-cycle tick from the autonomous clock |
| bus_clk_on_i | input | 1 | High in cycles where the bus clock runs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 period, 2 status |
| wr_data_i | input | 16 | Register write data |
| elapsed_o | output | 1 | Sticky elapsed flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as an expiry. It needs a period of 0, a continuous tick and a status write, all lined up on one edge. The bench builds it by holding the autonomous tick high with period 0 and issuing the clear write in that same cycle. Two other cases are only visible through timing: a dropped period or source write, and a frozen bus count. For these the bench counts the qualifying ticks itself, under random tick patterns on both inputs, and expects the flag on exactly the tick its own count predicts.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
    // register addresses
    localparam int unsigned ADDR_CTRL   = 0;
    localparam int unsigned ADDR_PERIOD = 1;
    localparam int unsigned ADDR_STATUS = 2;

    // control field positions
    localparam int unsigned BIT_RUN = 0;
    localparam int unsigned BIT_SRC = 1;
    localparam int unsigned BIT_IE  = 2;

    // status field position
    localparam int unsigned BIT_FLAG = 0;

    typedef enum logic {
        SRC_AUTO = 1'b0,
        SRC_BUS  = 1'b1
    } tick_src_e;
endpackage

// File: rtl/ptt_cfg_regs.sv
module ptt_cfg_regs
    import ptt_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned DATA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic                run_o,
    output tick_src_e           src_o,
    output logic                ie_o,
    output logic [PERIOD_W-1:0] period_o,
    output logic                flag_clr_o
);
    typedef struct packed {
        logic                run;
        tick_src_e           src;
        logic                ie;
        logic [PERIOD_W-1:0] period;
    } cfg_t;

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADDR_CTRL);
    localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(ADDR_PERIOD);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(ADDR_STATUS);

    cfg_t cfg_d, cfg_q;
    logic clr_d;

    always_comb begin
        cfg_d = cfg_q;
        clr_d = 1'b0;
        if (wr_en_i) begin
            if (wr_addr_i == A_CTRL) begin
                cfg_d.run = wr_data_i[BIT_RUN];
                cfg_d.ie  = wr_data_i[BIT_IE];
                // the lock uses the run state held before this write
                if (!cfg_q.run) begin
                    cfg_d.src = tick_src_e'(wr_data_i[BIT_SRC]);
                end
            end else if (wr_addr_i == A_PERIOD) begin
                if (!cfg_q.run) begin
                    cfg_d.period = wr_data_i[PERIOD_W-1:0];
                end
            end else if (wr_addr_i == A_STATUS) begin
                clr_d = wr_data_i[BIT_FLAG];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{run: 1'b0, src: SRC_AUTO, ie: 1'b0, period: '0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign run_o      = cfg_q.run;
    assign src_o      = cfg_q.src;
    assign ie_o       = cfg_q.ie;
    assign period_o   = cfg_q.period;
    assign flag_clr_o = clr_d;
endmodule

// File: rtl/ptt_tick_sel.sv
module ptt_tick_sel
    import ptt_pkg::*;
(
    input  tick_src_e src_i,
    input  logic      auto_tick_i,
    input  logic      bus_clk_on_i,
    output logic      tick_o
);
    always_comb begin
        unique case (src_i)
            SRC_BUS:  tick_o = bus_clk_on_i;
            default:  tick_o = auto_tick_i;
        endcase
    end
endmodule

// File: rtl/ptt_counter.sv
module ptt_counter #(
    parameter int unsigned PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] period_i,
    input  logic                flag_clr_i,
    output logic [PERIOD_W-1:0] count_o,
    output logic                expire_o,
    output logic                flag_o
);
    typedef struct packed {
        logic [PERIOD_W-1:0] cnt;
        logic                flag;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire_d;

    always_comb begin
        st_d     = st_q;
        expire_d = run_i && tick_i && (st_q.cnt == period_i);
        if (!run_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            st_d.cnt = expire_d ? '0 : st_q.cnt + 1'b1;
        end
        // expiry has priority over a clear in the same cycle
        if (expire_d) begin
            st_d.flag = 1'b1;
        end else if (flag_clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o  = st_q.cnt;
    assign expire_o = expire_d;
    assign flag_o   = st_q.flag;
endmodule

// File: rtl/periodic_tick_timer.sv
module periodic_tick_timer
    import ptt_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned ADDR_W   = 2,
    parameter int unsigned DATA_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_tick_i,
    input  logic              bus_clk_on_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              elapsed_o,
    output logic              irq_o
);
    logic                run_w;
    tick_src_e           src_w;
    logic                ie_w;
    logic [PERIOD_W-1:0] period_w;
    logic                flag_clr_w;
    logic                tick_w;
    logic [PERIOD_W-1:0] count_w;
    logic                expire_w;
    logic                flag_w;

    ptt_cfg_regs #(
        .PERIOD_W (PERIOD_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .run_o      (run_w),
        .src_o      (src_w),
        .ie_o       (ie_w),
        .period_o   (period_w),
        .flag_clr_o (flag_clr_w)
    );

    ptt_tick_sel u_sel (
        .src_i        (src_w),
        .auto_tick_i  (auto_tick_i),
        .bus_clk_on_i (bus_clk_on_i),
        .tick_o       (tick_w)
    );

    ptt_counter #(
        .PERIOD_W (PERIOD_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run_w),
        .tick_i     (tick_w),
        .period_i   (period_w),
        .flag_clr_i (flag_clr_w),
        .count_o    (count_w),
        .expire_o   (expire_w),
        .flag_o     (flag_w)
    );

    assign elapsed_o = flag_w;
    assign irq_o     = flag_w & ie_w;
endmodule

// File: rtl/ptt_checker.sv
module ptt_checker
    import ptt_pkg::*;
#(
    parameter int unsigned PERIOD_W = 16,
    parameter int unsigned ADDR_W   = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_clk_on,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic                run,
    input tick_src_e           src,
    input logic [PERIOD_W-1:0] period,
    input logic [PERIOD_W-1:0] count,
    input logic                expire,
    input logic                flag,
    input logic                irq
);
    a_r6_period_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && wr_addr == ADDR_W'(ADDR_PERIOD)) |=> $stable(period));

    a_r7_src_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wr_en && wr_addr == ADDR_W'(ADDR_CTRL)) |=> $stable(src));

    a_r5_bus_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (run && src == SRC_BUS && !bus_clk_on) |=> $stable(count));

    a_r9_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    a_r2_flag_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(expire));

    a_r10_stop_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |=> (count == '0));

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (count <= period));
endmodule

bind periodic_tick_timer ptt_checker #(
    .PERIOD_W (PERIOD_W),
    .ADDR_W   (ADDR_W)
) u_ptt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_clk_on (bus_clk_on_i),
    .wr_en      (wr_en_i),
    .wr_addr    (wr_addr_i),
    .run        (run_w),
    .src        (src_w),
    .period     (period_w),
    .count      (count_w),
    .expire     (expire_w),
    .flag       (flag_w),
    .irq        (irq_o)
);

// File: tb/periodic_tick_timer_bench.sv
`timescale 1ns/1ps
module periodic_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        auto_tick = 1'b0;
    logic        bus_on = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        elapsed;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    periodic_tick_timer u_periodic_tick_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .auto_tick_i  (auto_tick),
        .bus_clk_on_i (bus_on),
        .wr_en_i      (wr_en),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .elapsed_o    (elapsed),
        .irq_o        (irq)
    );

    function automatic int ticks_for(input int period);
        return period + 1;
    endfunction

    function automatic logic [15:0] ctrl_word(input bit run, input bit src, input bit ie);
        return {13'd0, ie, src, run};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // called at a negedge, returns at a negedge
    task automatic wr(input int addr, input logic [15:0] data);
        wr_en   = 1'b1;
        wr_addr = 2'(addr);
        wr_data = data;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // random ticks on both inputs; counts the selected one and expects the
    // flag exactly when the count reaches need
    task automatic expect_period(input int need, input bit use_bus, input string req);
        int n = 0;
        bit hit = 1'b0;
        for (int c = 0; c < 4000 && !hit; c++) begin
            auto_tick = (($urandom % 3) != 0);
            bus_on    = (($urandom % 3) != 0);
            @(posedge clk);
            if (use_bus ? bus_on : auto_tick) n++;
            @(negedge clk);
            if (n >= need) begin
                check(elapsed == 1'b1, req, elapsed, 1);
                hit = 1'b1;
            end else if (elapsed) begin
                check(1'b0, req, n, need);
                hit = 1'b1;
            end
        end
        if (!hit) check(1'b0, req, n, need);
        auto_tick = 1'b0;
        bus_on    = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd51966));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and default period 0
        check(elapsed == 1'b0, "R1 flag", elapsed, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, 0, 0));
        expect_period(ticks_for(0), 1'b0, "R1 default period");

        // R8: irq follows flag and enable
        check(irq == 1'b0, "R8 ie=0", irq, 0);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, 0, 1));
        check(irq == 1'b1, "R8 ie=1", irq, 1);
        wr(ptt_pkg::ADDR_STATUS, 16'h1);
        check(elapsed == 1'b0, "R9 clear", elapsed, 0);
        check(irq == 1'b0, "R8 flag low", irq, 0);

        // R11 + R9: period 0, expiry on every tick beats a clear
        auto_tick = 1'b1;
        wr_en = 1'b1; wr_addr = 2'(ptt_pkg::ADDR_STATUS); wr_data = 16'h1;
        @(posedge clk);
        @(negedge clk);
        check(elapsed == 1'b1, "R9 expiry wins", elapsed, 1);
        auto_tick = 1'b0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        check(elapsed == 1'b0, "R9 clear w/o expiry", elapsed, 0);
        auto_tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        auto_tick = 1'b0;
        check(elapsed == 1'b1, "R11 every tick", elapsed, 1);
        wr(ptt_pkg::ADDR_STATUS, 16'h1);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(0, 0, 0));

        // R6: period write while running dropped; R3 auto restart
        wr(ptt_pkg::ADDR_PERIOD, 16'd5);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, 0, 0));
        wr(ptt_pkg::ADDR_PERIOD, 16'd1);
        expect_period(ticks_for(5), 1'b0, "R2 first period");
        wr(ptt_pkg::ADDR_STATUS, 16'h1);
        expect_period(ticks_for(5), 1'b0, "R6 locked period / R3 restart");
        wr(ptt_pkg::ADDR_STATUS, 16'h1);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(0, 0, 0));

        // R7: source write while running dropped
        wr(ptt_pkg::ADDR_PERIOD, 16'd6);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, 0, 0));
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, 1, 0));
        expect_period(ticks_for(6), 1'b0, "R7 source locked");
        wr(ptt_pkg::ADDR_STATUS, 16'h1);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(0, 0, 0));

        // R5: bus source frozen while bus clock is off
        wr(ptt_pkg::ADDR_PERIOD, 16'd3);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, 1, 0));
        auto_tick = 1'b1;
        bus_on    = 1'b0;
        repeat (10) @(negedge clk);
        check(elapsed == 1'b0, "R5 frozen / R4 auto ignored", elapsed, 0);
        auto_tick = 1'b0;
        expect_period(ticks_for(3), 1'b1, "R5 resume");
        wr(ptt_pkg::ADDR_STATUS, 16'h1);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(0, 1, 0));

        // R10: stop restarts a full period
        wr(ptt_pkg::ADDR_PERIOD, 16'd7);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, 0, 0));
        auto_tick = 1'b1;
        repeat (4) @(negedge clk);
        auto_tick = 1'b0;
        check(elapsed == 1'b0, "R10 partial", elapsed, 0);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(0, 0, 0));
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, 0, 0));
        expect_period(ticks_for(7), 1'b0, "R10 full period");
        wr(ptt_pkg::ADDR_STATUS, 16'h1);
        wr(ptt_pkg::ADDR_CTRL, ctrl_word(0, 0, 0));

        // random: R2/R3/R4 over both sources
        for (int i = 0; i < 24; i++) begin
            int p = $urandom % 13;
            bit s = 1'($urandom % 2);
            wr(ptt_pkg::ADDR_PERIOD, 16'(p));
            wr(ptt_pkg::ADDR_CTRL, ctrl_word(1, s, 1));
            expect_period(ticks_for(p), s, "R2/R4 random");
            check(irq == 1'b1, "R8 random", irq, 1);
            wr(ptt_pkg::ADDR_STATUS, 16'h1);
            expect_period(ticks_for(p), s, "R3 random restart");
            wr(ptt_pkg::ADDR_STATUS, 16'h1);
            wr(ptt_pkg::ADDR_CTRL, ctrl_word(0, s, 0));
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule